// File: doc/BRIEF.md
# Four-Mode Configurable Port Pin Controller

This block turns the register state of an eight-pin I/O port into the digital pad controls that an analog pad cell needs. Each pin has its own output latch bit and a two-bit mode. The mode selects one of four behaviours: quasi-bidirectional, push-pull, input-only (high impedance) and open-drain. From the mode and the effective output value, the block drives five controls per pin: a strong pull-down, a strong pull-up, a weak pull-up, a very weak pull-up and an input enable.

Quasi-bidirectional pins need three pull-up strengths. The very weak one holds a released line high. The weak one keeps a line high once it has been seen high. A short strong pulse speeds up the rising edge after the output goes from 0 to 1. That pulse makes the block sequential. The pin value the weak pull-up depends on is taken from a register, so no combinational path leads from the pad back into the pad controls.

Software-visible reads come out on two paths. One returns the pin levels and one returns the latch, which read-modify-write instructions use. An on-chip peripheral can share a pin: its output is ANDed with the latch bit. In power-down the input buffers of all pins except the wake-up pins are shut off.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The mode code of a pin is {mode_hi, mode_lo}: 00 quasi-bidirectional, 01 push-pull, 10 input-only, 11 open-drain. An input-only pin drives none of pull_dn, up_strong, up_weak and up_vweak, whatever its latch holds.
- R2: In modes 00, 01 and 11, pull_dn is high exactly when the pin's effective output is 0. pull_dn is never high together with any pull-up on the same pin.
- R3: In push-pull mode, up_strong follows the effective output, and up_weak and up_vweak stay low.
- R4: In quasi-bidirectional mode, up_vweak is high exactly when the effective output is 1.
- R5: In quasi-bidirectional mode, up_weak is high when the effective output is 1 and the gated pin value registered at the previous clock edge was 1. The pin level in the current cycle has no effect on up_weak.
- R6: In quasi-bidirectional mode, a 0-to-1 change of the effective output raises up_strong for exactly two cycles. The first of these is the cycle in which the new value is first seen. The pulse ends early if the output returns to 0 or the mode changes. A steady 1 never raises it again.
- R7: Reset is synchronous and active low. Every latch bit resets to 1. Pins 0 and 1 reset to input-only. The other pins reset to input-only when tri_default is 1 and to quasi-bidirectional when it is 0.
- R8: rd_pin returns the gated pad levels in the same cycle, and rd_latch returns the latch contents, independent of the pads.
- R9: While powerdown is 1, in_en and rd_pin are 0 on every pin except the wake-up pins 2 and 3, which stay enabled. With powerdown 0, in_en is 1 on all pins.
- R10: For a pin whose alt_en bit is 1, the effective output is its latch bit ANDed with its alt_out bit. Otherwise the effective output is the latch bit. rd_latch always shows the latch itself.
- R11: latch_we loads latch_wd into all latch bits at the clock edge. mode_lo_we loads mode_wd into the low mode bits and mode_hi_we loads it into the high mode bits, each write leaving the other plane unchanged. A write takes effect in the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tri_default | input | 1 | Reset option: 1 makes pins 2..7 reset to input-only |
| latch_we | input | 1 | Latch write strobe |
| latch_wd | input | 8 | Latch write data |
| mode_lo_we | input | 1 | Low mode-bit plane write strobe |
| mode_hi_we | input | 1 | High mode-bit plane write strobe |
| mode_wd | input | 8 | Mode plane write data |
| alt_en | input | 8 | Per-pin peripheral output select |
| alt_out | input | 8 | Per-pin peripheral output value |
| pad_in | input | 8 | Raw pad levels |
| powerdown | input | 1 | Power-down state, gates inputs |
| rd_pin | output | 8 | Pin read path (gated pad levels) |
| rd_latch | output | 8 | Latch read path for read-modify-write |
| in_en | output | 8 | Input buffer enable per pin |
| pull_dn | output | 8 | Strong pull-down per pin |
| up_strong | output | 8 | Strong pull-up per pin |
| up_weak | output | 8 | Weak pull-up per pin |
| up_vweak | output | 8 | Very weak pull-up per pin |

## Verification
Latch patterns are written under each uniform mode and under mixed per-pin modes. Comparing pull_dn with the pull-ups across these cases separates the four mode decodes and shows whether an input-only pin stays quiet. Writing 0 and then all ones in quasi mode, and holding 1 afterwards, tells a two-cycle pulse from a one- or three-cycle pulse or a level. Changing pad_in inside a cycle tells a registered weak pull-up decision from a combinational one. Power-down with all pads high separates the wake-up pins from the gated ones, and long pseudo-random runs over every input mix alternate-function masking with pulse restarts and mode writes.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    PM_QUASI = 2'b00,
    PM_PUSH  = 2'b01,
    PM_HIZ   = 2'b10,
    PM_OPEN  = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic pull_dn;
    logic up_strong;
    logic up_weak;
    logic up_vweak;
  } pad_ctl_t;

  // Mode a pin takes at reset
  function automatic pin_mode_e reset_mode(input logic forced_hiz, input logic tri_opt);
    return (forced_hiz || tri_opt) ? PM_HIZ : PM_QUASI;
  endfunction

  // Pad control decode for one pin
  function automatic pad_ctl_t decode_pad(input pin_mode_e m, input logic drv,
                                          input logic pulse, input logic pin_seen);
    pad_ctl_t c;
    c = '0;
    unique case (m)
      PM_QUASI: begin
        c.pull_dn   = ~drv;
        c.up_vweak  = drv;
        c.up_weak   = drv & pin_seen;
        c.up_strong = drv & pulse;
      end
      PM_PUSH: begin
        c.pull_dn   = ~drv;
        c.up_strong = drv;
      end
      PM_OPEN: begin
        c.pull_dn   = ~drv;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
#(
  parameter int          W         = 8,
  parameter logic [W-1:0] FORCED_IN = 8'h03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tri_default,
  input  logic         latch_we,
  input  logic [W-1:0] latch_wd,
  input  logic         mode_lo_we,
  input  logic         mode_hi_we,
  input  logic [W-1:0] mode_wd,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] mode_lo_q,
  output logic [W-1:0] mode_hi_q
);

  logic [W-1:0] rst_lo;
  logic [W-1:0] rst_hi;

  for (genvar i = 0; i < W; i++) begin : g_rst
    pin_mode_e rm;
    assign rm        = reset_mode(FORCED_IN[i], tri_default);
    assign rst_lo[i] = rm[0];
    assign rst_hi[i] = rm[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '1;
      mode_lo_q <= rst_lo;
      mode_hi_q <= rst_hi;
    end else begin
      if (latch_we)   latch_q   <= latch_wd;
      if (mode_lo_we) mode_lo_q <= mode_wd;
      if (mode_hi_we) mode_hi_q <= mode_wd;
    end
  end

endmodule

// File: rtl/cfg_port_pulse.sv
module cfg_port_pulse #(
  parameter int W    = 8,
  parameter int HOLD = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] drv,
  input  logic [W-1:0] quasi,
  output logic [W-1:0] pulse_start,
  output logic [W-1:0] pulse_on
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD - 1);

  logic [W-1:0] drv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) drv_q <= '1;
    else        drv_q <= drv;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] left;

    assign pulse_start[i] = quasi[i] & drv[i] & ~drv_q[i];
    assign pulse_on[i]    = pulse_start[i] | (left != '0);

    always_ff @(posedge clk) begin
      if (!rst_n)                left <= '0;
      else if (!quasi[i] || !drv[i]) left <= '0;
      else if (pulse_start[i])   left <= RELOAD;
      else if (left != '0)       left <= left - 1'b1;
    end
  end

endmodule

// File: rtl/cfg_port_sense.sv
module cfg_port_sense #(
  parameter int           W    = 8,
  parameter logic [W-1:0] WAKE = 8'h0C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic         powerdown,
  output logic [W-1:0] in_en,
  output logic [W-1:0] pin_rd,
  output logic [W-1:0] pin_seen
);

  assign in_en  = powerdown ? WAKE : '1;
  assign pin_rd = pad_in & in_en;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_seen <= '0;
    else        pin_seen <= pin_rd;
  end

endmodule

// File: rtl/cfg_port_drive.sv
module cfg_port_drive
  import cfg_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] mode_lo,
  input  logic [W-1:0] mode_hi,
  input  logic [W-1:0] drv,
  input  logic [W-1:0] pulse_on,
  input  logic [W-1:0] pin_seen,
  output logic [W-1:0] pull_dn,
  output logic [W-1:0] up_strong,
  output logic [W-1:0] up_weak,
  output logic [W-1:0] up_vweak
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    pad_ctl_t c;
    assign c = decode_pad(pin_mode_e'({mode_hi[i], mode_lo[i]}), drv[i], pulse_on[i], pin_seen[i]);
    assign pull_dn[i]   = c.pull_dn;
    assign up_strong[i] = c.up_strong;
    assign up_weak[i]   = c.up_weak;
    assign up_vweak[i]  = c.up_vweak;
  end

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int           W         = 8,
  parameter int           HOLD      = 2,
  parameter logic [W-1:0] FORCED_IN = 8'h03,
  parameter logic [W-1:0] WAKE      = 8'h0C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tri_default,
  input  logic         latch_we,
  input  logic [W-1:0] latch_wd,
  input  logic         mode_lo_we,
  input  logic         mode_hi_we,
  input  logic [W-1:0] mode_wd,
  input  logic [W-1:0] alt_en,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] pad_in,
  input  logic         powerdown,
  output logic [W-1:0] rd_pin,
  output logic [W-1:0] rd_latch,
  output logic [W-1:0] in_en,
  output logic [W-1:0] pull_dn,
  output logic [W-1:0] up_strong,
  output logic [W-1:0] up_weak,
  output logic [W-1:0] up_vweak
);

  logic [W-1:0] latch_w;
  logic [W-1:0] mode_lo_w;
  logic [W-1:0] mode_hi_w;
  logic [W-1:0] drv_w;
  logic [W-1:0] quasi_w;
  logic [W-1:0] push_w;
  logic [W-1:0] hiz_w;
  logic [W-1:0] pulse_start_w;
  logic [W-1:0] pulse_on_w;
  logic [W-1:0] pin_seen_w;

  cfg_port_regs #(.W(W), .FORCED_IN(FORCED_IN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .tri_default(tri_default),
    .latch_we   (latch_we),
    .latch_wd   (latch_wd),
    .mode_lo_we (mode_lo_we),
    .mode_hi_we (mode_hi_we),
    .mode_wd    (mode_wd),
    .latch_q    (latch_w),
    .mode_lo_q  (mode_lo_w),
    .mode_hi_q  (mode_hi_w)
  );

  assign drv_w   = latch_w & (~alt_en | alt_out);
  assign quasi_w = ~mode_hi_w & ~mode_lo_w;
  assign push_w  = ~mode_hi_w &  mode_lo_w;
  assign hiz_w   =  mode_hi_w & ~mode_lo_w;

  cfg_port_pulse #(.W(W), .HOLD(HOLD)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .drv        (drv_w),
    .quasi      (quasi_w),
    .pulse_start(pulse_start_w),
    .pulse_on   (pulse_on_w)
  );

  cfg_port_sense #(.W(W), .WAKE(WAKE)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .powerdown(powerdown),
    .in_en    (in_en),
    .pin_rd   (rd_pin),
    .pin_seen (pin_seen_w)
  );

  cfg_port_drive #(.W(W)) u_drive (
    .mode_lo  (mode_lo_w),
    .mode_hi  (mode_hi_w),
    .drv      (drv_w),
    .pulse_on (pulse_on_w),
    .pin_seen (pin_seen_w),
    .pull_dn  (pull_dn),
    .up_strong(up_strong),
    .up_weak  (up_weak),
    .up_vweak (up_vweak)
  );

  assign rd_latch = latch_w;

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int           W    = 8,
  parameter int           HOLD = 2,
  parameter logic [W-1:0] WAKE = 8'h0C
) (
  input logic         clk,
  input logic         rst_n,
  input logic         powerdown,
  input logic [W-1:0] pad_in,
  input logic         latch_we,
  input logic [W-1:0] latch_wd,
  input logic [W-1:0] rd_latch,
  input logic [W-1:0] rd_pin,
  input logic [W-1:0] pull_dn,
  input logic [W-1:0] up_strong,
  input logic [W-1:0] up_weak,
  input logic [W-1:0] up_vweak,
  input logic [W-1:0] hiz_w,
  input logic [W-1:0] push_w,
  input logic [W-1:0] quasi_w,
  input logic [W-1:0] drv_w,
  input logic [W-1:0] pulse_start_w
);

  assert_hiz_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((hiz_w & (pull_dn | up_strong | up_weak | up_vweak)) == '0));

  assert_no_contention_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_dn & (up_strong | up_weak | up_vweak)) == '0));

  assert_push_no_weak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((push_w & (up_weak | up_vweak)) == '0));

  assert_weak_needs_seen_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_weak & ~$past(pad_in)) == '0));

  assert_latch_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    latch_we |=> (rd_latch == $past(latch_wd)));

  assert_powerdown_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    powerdown |-> ((rd_pin & ~WAKE) == '0));

  for (genvar i = 0; i < W; i++) begin : g_pin
    assert_pulse_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_start_w[i] |-> up_strong[i]);

    assert_pulse_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_start_w[i] |=> (up_strong[i] || !drv_w[i] || !quasi_w[i]));

    if (HOLD == 2) begin : g_end
      assert_pulse_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pulse_start_w[i], 2) && !$past(pulse_start_w[i]) && !pulse_start_w[i])
        |-> !(quasi_w[i] && up_strong[i]));
    end
  end

endmodule

bind cfg_port_ctrl cfg_port_chk #(.W(W), .HOLD(HOLD), .WAKE(WAKE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .powerdown    (powerdown),
  .pad_in       (pad_in),
  .latch_we     (latch_we),
  .latch_wd     (latch_wd),
  .rd_latch     (rd_latch),
  .rd_pin       (rd_pin),
  .pull_dn      (pull_dn),
  .up_strong    (up_strong),
  .up_weak      (up_weak),
  .up_vweak     (up_vweak),
  .hiz_w        (hiz_w),
  .push_w       (push_w),
  .quasi_w      (quasi_w),
  .drv_w        (drv_w),
  .pulse_start_w(pulse_start_w)
);

// File: tb/test_cfg_port_ctrl.sv
module test_cfg_port_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tri_default = 1'b0;
  logic       latch_we = 1'b0;
  logic [7:0] latch_wd = '0;
  logic       mode_lo_we = 1'b0;
  logic       mode_hi_we = 1'b0;
  logic [7:0] mode_wd = '0;
  logic [7:0] alt_en = '0;
  logic [7:0] alt_out = '0;
  logic [7:0] pad_in = 8'hFF;
  logic       powerdown = 1'b0;
  logic [7:0] rd_pin, rd_latch, in_en, pull_dn, up_strong, up_weak, up_vweak;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cfg_port_ctrl i_cfg_port_ctrl (
    .clk(clk), .rst_n(rst_n), .tri_default(tri_default),
    .latch_we(latch_we), .latch_wd(latch_wd),
    .mode_lo_we(mode_lo_we), .mode_hi_we(mode_hi_we), .mode_wd(mode_wd),
    .alt_en(alt_en), .alt_out(alt_out), .pad_in(pad_in), .powerdown(powerdown),
    .rd_pin(rd_pin), .rd_latch(rd_latch), .in_en(in_en), .pull_dn(pull_dn),
    .up_strong(up_strong), .up_weak(up_weak), .up_vweak(up_vweak)
  );

  // Behavioural reference state, one entry per pin
  int m_lat[8];
  int m_md[8];     // 0 quasi, 1 push, 2 input-only, 3 open-drain
  int m_seen[8];
  int m_prev[8];
  int m_left[8];

  function automatic int eff(int i);
    return (alt_en[i] ? (m_lat[i] & int'(alt_out[i])) : m_lat[i]);
  endfunction

  function automatic int gate(int i);
    if (!powerdown) return 1;
    return (i == 2 || i == 3) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (!rst_n) begin
        m_lat[i]  = 1;
        m_md[i]   = (i < 2 || tri_default) ? 2 : 0;
        m_seen[i] = 0;
        m_prev[i] = 1;
        m_left[i] = 0;
      end else begin
        int d;
        bit rise;
        d    = eff(i);
        rise = (m_md[i] == 0) && (d == 1) && (m_prev[i] == 0);
        if (m_md[i] != 0 || d == 0) m_left[i] = 0;
        else if (rise)               m_left[i] = 1;
        else if (m_left[i] > 0)      m_left[i] = m_left[i] - 1;
        m_prev[i] = d;
        m_seen[i] = int'(pad_in[i]) & gate(i);
        if (latch_we)   m_lat[i] = int'(latch_wd[i]);
        if (mode_lo_we) m_md[i]  = (m_md[i] & 2) | int'(mode_wd[i]);
        if (mode_hi_we) m_md[i]  = (m_md[i] & 1) | (int'(mode_wd[i]) << 1);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, 5 ns after the input update
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && !done) begin
        logic [7:0] e_pd, e_ps, e_pw, e_pv, e_en, e_rp, e_rl;
        for (int i = 0; i < 8; i++) begin
          int d;
          bit rise;
          d    = eff(i);
          rise = (m_md[i] == 0) && (d == 1) && (m_prev[i] == 0);
          e_pd[i] = (m_md[i] != 2) && (d == 0);
          e_ps[i] = ((m_md[i] == 1) && d == 1) ||
                    ((m_md[i] == 0) && d == 1 && (rise || m_left[i] > 0));
          e_pw[i] = (m_md[i] == 0) && d == 1 && m_seen[i] == 1;
          e_pv[i] = (m_md[i] == 0) && d == 1;
          e_en[i] = gate(i) == 1;
          e_rp[i] = pad_in[i] & e_en[i];
          e_rl[i] = m_lat[i] == 1;
        end
        chk("R2 pull_dn model", pull_dn, e_pd);
        chk("R6 up_strong model", up_strong, e_ps);
        chk("R5 up_weak model", up_weak, e_pw);
        chk("R4 up_vweak model", up_vweak, e_pv);
        chk("R9 in_en model", in_en, e_en);
        chk("R8 rd_pin model", rd_pin, e_rp);
        chk("R8 rd_latch model", rd_latch, e_rl);
      end
    end
  end

  task automatic nxt();
    @(negedge clk);
    latch_we   = 1'b0;
    mode_lo_we = 1'b0;
    mode_hi_we = 1'b0;
  endtask

  task automatic look();
    #6;
  endtask

  task automatic set_modes(input logic [7:0] lo, input logic [7:0] hi);
    nxt(); mode_lo_we = 1'b1; mode_hi_we = 1'b1; mode_wd = lo;
    nxt(); mode_hi_we = 1'b1; mode_wd = hi;
  endtask

  task automatic wr_latch(input logic [7:0] v);
    nxt(); latch_we = 1'b1; latch_wd = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lcg;
    // Reset with tri_default = 0
    repeat (4) nxt();
    rst_n = 1'b1;
    nxt(); look();
    chk("R7 latch resets to ones", rd_latch, 8'hFF);
    chk("R7 pins 0,1 input-only, rest quasi", up_vweak, 8'hFC);
    chk("R7 no pull-down after reset", pull_dn, 8'h00);
    chk("R1 forced pins quiet", up_weak & 8'h03, 8'h00);

    // Reset with tri_default = 1
    nxt(); rst_n = 1'b0; tri_default = 1'b1;
    nxt(); nxt(); rst_n = 1'b1;
    nxt(); look();
    chk("R7 all input-only with option", up_vweak, 8'h00);
    chk("R1 input-only drives nothing", pull_dn | up_strong | up_weak, 8'h00);
    chk("R9 inputs enabled outside power-down", in_en, 8'hFF);

    // Quasi mode everywhere, pulse behaviour
    set_modes(8'h00, 8'h00);
    wr_latch(8'h00);
    nxt(); look();
    chk("R2 quasi latch 0 pulls down", pull_dn, 8'hFF);
    chk("R4 quasi latch 0 no very weak", up_vweak, 8'h00);
    wr_latch(8'hFF);
    nxt(); look();
    chk("R6 pulse cycle 1", up_strong, 8'hFF);
    nxt(); look();
    chk("R6 pulse cycle 2", up_strong, 8'hFF);
    nxt(); look();
    chk("R6 pulse over", up_strong, 8'h00);
    chk("R4 very weak held", up_vweak, 8'hFF);
    wr_latch(8'hFF);
    nxt(); look();
    chk("R6 steady 1 no new pulse", up_strong, 8'h00);

    // Weak pull-up uses the registered pin value
    nxt(); pad_in = 8'h0F;
    nxt(); look();
    chk("R5 weak follows sampled pin", up_weak, 8'h0F);
    nxt(); pad_in = 8'hF0; look();
    chk("R5 current pin has no effect yet", up_weak, 8'h0F);
    nxt(); look();
    chk("R5 weak after next sample", up_weak, 8'hF0);

    // Push-pull
    set_modes(8'hFF, 8'h00);
    wr_latch(8'hA5);
    nxt(); look();
    chk("R3 push-pull strong up", up_strong, 8'hA5);
    chk("R3 push-pull pull down", pull_dn, 8'h5A);
    chk("R3 push-pull no weak", up_weak | up_vweak, 8'h00);

    // Plane independence: only low plane written
    set_modes(8'h00, 8'hF0);
    nxt(); mode_lo_we = 1'b1; mode_wd = 8'hFF;
    wr_latch(8'h00);
    nxt(); look();
    chk("R11 low write keeps high plane (open/push)", pull_dn, 8'hFF);
    wr_latch(8'hFF);
    nxt(); look();
    chk("R1 open-drain drives nothing high", up_strong, 8'h0F);

    // Read paths
    wr_latch(8'h3C);
    nxt(); pad_in = 8'hC3; look();
    chk("R8 pin read", rd_pin, 8'hC3);
    chk("R8 latch read", rd_latch, 8'h3C);

    // Power-down gating
    nxt(); powerdown = 1'b1; pad_in = 8'hFF; look();
    chk("R9 power-down in_en", in_en, 8'h0C);
    chk("R9 power-down rd_pin", rd_pin, 8'h0C);
    nxt(); powerdown = 1'b0;

    // Alternate function
    set_modes(8'hFF, 8'h00);
    wr_latch(8'hFF);
    nxt(); alt_en = 8'hF0; alt_out = 8'h30; look();
    chk("R10 alt AND latch", up_strong, 8'h3F);
    chk("R10 latch read unaffected", rd_latch, 8'hFF);
    nxt(); alt_en = 8'h00;

    // Pseudo-random mix, reference compared every cycle
    lcg = 32'h1234_5678;
    for (int k = 0; k < 600; k++) begin
      nxt();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      latch_we   = lcg[31] & lcg[30];
      latch_wd   = lcg[23:16];
      mode_lo_we = (lcg[29:27] == 3'd0);
      mode_hi_we = (lcg[26:24] == 3'd0);
      mode_wd    = lcg[15:8];
      pad_in     = lcg[7:0] ^ lcg[22:15];
      alt_en     = (k > 300) ? lcg[13:6] : 8'h00;
      alt_out    = lcg[20:13];
      powerdown  = (lcg[5:3] == 3'd7);
    end
    nxt();
    finish_run();
  end

endmodule